// File: doc/BRIEF.md
# Multi-Lane Double-Edge Serial Word Deserializer

This block turns several parallel serial lanes from an image sensor or ADC into one 12-bit parallel word per lane per frame. On each lane one bit is taken on each edge of a fast bit clock. Upstream capture logic presents the two samples of one bit-clock period as a pair of single-bit inputs: the rising-edge sample and the falling-edge sample. Every clock cycle of the block therefore delivers two bits per lane. A 12-bit word takes six cycles.

A frame clock, sampled in the same domain, marks where each word begins. Its rising edge restarts a shared bit counter. If a complete word has been gathered by then, every lane's word moves to its output register together and a one-cycle valid strobe is raised. The strobe recurs once per frame, so it serves as the word-rate enable for the logic downstream.

Each word is built from two 6-bit halves. The half that arrives first lands in the low bits of the output and the half that arrives second lands in the high bits. Frames of the wrong length are discarded and raise an alignment-error flag.

Top module: `ddr_word_deser`

## Requirements
- R1: A synchronous active-high reset clears every output: word bus zero, valid low, error low, starting in the cycle after the reset is sampled.
- R2: Within each lane, bits arrive in time order with the rising-edge sample before the falling-edge sample of the same cycle. The first 6 bits form the low half [5:0] and the next 6 bits form the high half [11:6]. Within each half the earliest bit is the most significant.
- R3: The four lanes are independent. Lane n occupies word_o[12n+11:12n], and all lanes present their words in the same cycle.
- R4: When a frame rising edge ends a frame of exactly 6 cycles (12 bits), the finished words appear and valid_o is high for exactly one cycle. This is the cycle after the clock edge that sampled the frame edge.
- R5: The first frame edge after reset only establishes alignment and emits no word.
- R6: A frame edge that arrives after fewer than 12 bits discards the partial word, emits no valid, and sets align_err_o.
- R7: A frame edge that arrives after more than 12 bits is treated the same way: no valid, and align_err_o set.
- R8: align_err_o stays set until the next complete word, and it clears in the same cycle that the word's valid appears.
- R9: word_o holds its value between valid strobes.
- R10: Bits received before the first frame edge after reset produce neither a valid strobe nor an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; one rising and one falling sample per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Frame clock sampled in the capture domain; its rising edge starts a word |
| rise_i | input | LANES | Rising-edge bit sample, one per lane |
| fall_i | input | LANES | Falling-edge bit sample, one per lane |
| word_o | output | LANES*WORD_W | Assembled words, lane n at bits [WORD_W*n +: WORD_W] |
| valid_o | output | 1 | One-cycle strobe per completed word |
| align_err_o | output | 1 | Set by a frame of wrong length, cleared by the next good word |

## Verification
The bench targets the following corner cases and shows how a faulty design would fail each one.
- Bit and half ordering uses asymmetric words on every lane. Swapped halves, a reversed bit order or a swapped rise/fall pair would put the wrong value on the bus.
- Short frames are sent back to back, and a long frame is also sent. A design that tests only for "at least 12 bits", or that clears the error on any frame edge, would emit a stale word or drop the flag too early.
- Bits are driven before the first frame edge, both after power-up and after a mid-stream reset. An aligner that counts from reset instead of from the first edge would raise a spurious error or a bogus word.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;
   // Placement of the first-arriving half within the output word
   typedef enum logic {
      EARLY_LOW  = 1'b0,
      EARLY_HIGH = 1'b1
   } half_order_e;

   // Samples delivered per lane per capture cycle (one per bit-clock edge)
   localparam int unsigned SMP_PER_CYC = 2;
endpackage

// File: rtl/ddr_frame_align.sv
module ddr_frame_align
   import ddr_deser_pkg::*;
#(
   parameter int unsigned WORD_W = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic frame_i,
   output logic take_o,
   output logic err_o
);
   localparam int unsigned CW = $clog2(WORD_W + SMP_PER_CYC + 1);
   localparam logic [CW-1:0] FULL = CW'(WORD_W);
   localparam logic [CW-1:0] SAT  = CW'(WORD_W + SMP_PER_CYC);
   localparam logic [CW-1:0] STEP = CW'(SMP_PER_CYC);

   logic          frame_q;
   logic          aligned;
   logic [CW-1:0] cnt;
   logic          fedge;

   assign fedge  = frame_i & ~frame_q;
   assign take_o = fedge & aligned & (cnt == FULL);

   always_ff @(posedge clk) begin
      if (rst) begin
         frame_q <= 1'b0;
         aligned <= 1'b0;
         cnt     <= '0;
         err_o   <= 1'b0;
      end else begin
         frame_q <= frame_i;
         if (fedge) begin
            aligned <= 1'b1;
            cnt     <= STEP;
            if (aligned) err_o <= (cnt != FULL);
         end else if (aligned && cnt < SAT) begin
            cnt <= cnt + STEP;
         end
      end
   end

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= SAT);
   // R2
   cnt_even_chk: assert property (@(posedge clk) disable iff (rst) cnt[0] == 1'b0);
   // R6
   err_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(frame_i && !frame_q) |=> $stable(err_o));
   // R10
   no_err_unaligned_chk: assert property (@(posedge clk) disable iff (rst)
      !aligned |-> !err_o);
endmodule

// File: rtl/ddr_lane_deser.sv
module ddr_lane_deser
   import ddr_deser_pkg::*;
#(
   parameter int unsigned WORD_W     = 12,
   parameter half_order_e HALF_ORDER = EARLY_LOW
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              take_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int unsigned HALF_W = WORD_W / 2;

   logic [WORD_W-1:0] sh;
   logic [WORD_W-1:0] arranged;

   // sh[WORD_W-1] holds the oldest of the last WORD_W samples
   always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[WORD_W-3:0], rise_i, fall_i};
   end

   generate
      if (HALF_ORDER == EARLY_LOW) begin : g_early_low
         assign arranged = {sh[HALF_W-1:0], sh[WORD_W-1:HALF_W]};
      end else begin : g_early_high
         assign arranged = sh;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)         word_o <= '0;
      else if (take_i) word_o <= arranged;
   end

   // R9
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !take_i |=> $stable(word_o));
endmodule

// File: rtl/ddr_word_deser.sv
module ddr_word_deser
   import ddr_deser_pkg::*;
#(
   parameter int unsigned LANES      = 4,
   parameter int unsigned WORD_W     = 12,
   parameter half_order_e HALF_ORDER = EARLY_LOW
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    frame_i,
   input  logic [LANES-1:0]        rise_i,
   input  logic [LANES-1:0]        fall_i,
   output logic [LANES*WORD_W-1:0] word_o,
   output logic                    valid_o,
   output logic                    align_err_o
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (WORD_W < 4 || (WORD_W % (2 * SMP_PER_CYC)) != 0) begin : g_bad_width
         $error("WORD_W must split into two halves of whole capture cycles");
      end
   endgenerate

   logic take;

   ddr_frame_align #(.WORD_W(WORD_W)) u_align (
      .clk     (clk),
      .rst     (rst),
      .frame_i (frame_i),
      .take_o  (take),
      .err_o   (align_err_o)
   );

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         ddr_lane_deser #(.WORD_W(WORD_W), .HALF_ORDER(HALF_ORDER)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .rise_i (rise_i[gl]),
            .fall_i (fall_i[gl]),
            .take_i (take),
            .word_o (word_o[gl*WORD_W +: WORD_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) valid_o <= 1'b0;
      else     valid_o <= take;
   end

   // R4
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> !valid_o);
   // R8
   valid_err_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> !align_err_o);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!valid_o && !align_err_o && word_o == '0));
endmodule

// File: tb/sim_ddr_word_deser.sv
module sim_ddr_word_deser;
   localparam int CLK_PERIOD = 10;
   localparam int L = 4;
   localparam int W = 12;
   localparam int NVEC = 11;

   // {frame length in cycles, lane3, lane2, lane1, lane0}
   localparam logic [4+L*W-1:0] VEC [NVEC] = '{
      {4'd6, 12'h7D2, 12'h81E, 12'h3F0, 12'hA5C},
      {4'd6, 12'hAAA, 12'h555, 12'h000, 12'hFFF},
      {4'd6, 12'hABC, 12'h789, 12'h456, 12'h123},
      {4'd4, 12'h111, 12'h222, 12'h333, 12'h444},
      {4'd4, 12'h999, 12'h888, 12'h777, 12'h666},
      {4'd6, 12'hCE1, 12'h68A, 12'h024, 12'hDEF},
      {4'd6, 12'hE1E, 12'h1E1, 12'hF0F, 12'h0F0},
      {4'd8, 12'h5A5, 12'hC3C, 12'h0FF, 12'hB4B},
      {4'd6, 12'hE61, 12'h2D8, 12'h4C7, 12'h9B3},
      {4'd6, 12'h020, 12'h040, 12'h001, 12'h800},
      {4'd6, 12'h000, 12'h000, 12'h000, 12'h000}
   };

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             frame_i = 1'b0;
   logic [L-1:0]     rise_i = '0;
   logic [L-1:0]     fall_i = '0;
   logic [L*W-1:0]   word_o;
   logic             valid_o;
   logic             align_err_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [L*W-1:0] held = '0;
   logic           err_m = 1'b0;
   logic           had_prev = 1'b0;
   logic           prev_full = 1'b0;
   logic [L*W-1:0] prev_words = '0;
   string          prev_tag = "R5";

   always #(CLK_PERIOD/2) clk = ~clk;

   ddr_word_deser u0 (
      .clk(clk), .rst(rst), .frame_i(frame_i), .rise_i(rise_i), .fall_i(fall_i),
      .word_o(word_o), .valid_o(valid_o), .align_err_o(align_err_o)
   );

   function automatic logic sbit(input logic [W-1:0] w, input int k);
      int kk = k % W;
      return (kk < W/2) ? w[W/2-1-kk] : w[W+W/2-1-kk];
   endfunction

   task automatic cyc(input logic fr, input logic [L-1:0] r, input logic [L-1:0] f,
                      input logic ev, input logic ee,
                      input string tv, input string tw, input string te);
      frame_i = fr; rise_i = r; fall_i = f;
      @(posedge clk); #1;
      n_cmp++;
      if (valid_o !== ev) begin
         n_bad++; $display("FAIL %s valid: got %0b exp %0b", tv, valid_o, ev);
      end
      n_cmp++;
      if (word_o !== held) begin
         n_bad++; $display("FAIL %s word: got %h exp %h", tw, word_o, held);
      end
      n_cmp++;
      if (align_err_o !== ee) begin
         n_bad++; $display("FAIL %s err: got %0b exp %0b", te, align_err_o, ee);
      end
   endtask

   task automatic idle(input int n);
      for (int c = 0; c < n; c++)
         cyc(1'b0, L'(c * 5 + 3), L'(c * 7 + 9), 1'b0, 1'b0, "R10", "R10", "R10");
   endtask

   task automatic send_frame(input int n, input logic [L*W-1:0] words);
      logic [L-1:0] r, f;
      logic ev;
      string tv, te, mytag;
      ev = had_prev && prev_full;
      if (ev) held = prev_words;
      if (had_prev) err_m = !prev_full;
      tv = had_prev ? prev_tag : "R5";
      te = ev ? "R8" : tv;
      mytag = (n == W/2) ? "R4" : ((n < W/2) ? "R6" : "R7");
      for (int c = 0; c < n; c++) begin
         for (int l = 0; l < L; l++) begin
            r[l] = sbit(words[l*W +: W], 2*c);
            f[l] = sbit(words[l*W +: W], 2*c + 1);
         end
         if (c == 0) cyc(1'b1, r, f, ev, err_m, tv, ev ? "R2 R3" : "R9", te);
         else        cyc(c < (n+1)/2, r, f, 1'b0, err_m, "R4", "R9", "R8");
      end
      had_prev = 1'b1;
      prev_full = (n == W/2);
      prev_words = words;
      prev_tag = mytag;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      held = '0; err_m = 1'b0; had_prev = 1'b0; prev_full = 1'b0; prev_tag = "R5";
      cyc(1'b0, '1, '1, 1'b0, 1'b0, "R1", "R1", "R1");
      cyc(1'b0, '0, '1, 1'b0, 1'b0, "R1", "R1", "R1");
      rst = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1;
      do_reset();
      idle(5);
      for (int i = 0; i < NVEC; i++)
         send_frame(int'(VEC[i][4+L*W-1 -: 4]), VEC[i][L*W-1:0]);
      // R1: reset in the middle of a stream clears all outputs
      do_reset();
      // R10: stray bits ahead of the first edge after reset
      idle(4);
      // R5: first edge only aligns; R2 R3: next edge delivers the word
      send_frame(6, {12'h3C5, 12'h96A, 12'h0F1, 12'hE2D});
      send_frame(4, {12'h111, 12'h111, 12'h111, 12'h111});
      send_frame(6, {12'h5E7, 12'h1B9, 12'hC48, 12'h7A2});
      send_frame(6, {12'h000, 12'h000, 12'h000, 12'h000});
      idle(0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule